// File: doc/BRIEF.md
# Address-Line Aliasing Tester

This controller checks every address line of an attached RAM for stuck or bridged faults. It does not wipe the array. For each address bit it selects two locations:

- a target, which has that bit set;
- an alias, the same address with that bit cleared.

If the line is faulty, these two locations collapse onto one cell. The controller saves both locations, zeroes the alias, fills the target with all ones, and reads both back. Only the target may have changed. It then writes the two saved words back, so the rest of the memory and these two words keep their contents.

Each bit is checked against two bases: address zero, and the all-ones address. The zero base catches a line stuck at one. The all-ones base catches a line stuck at zero and a line bridged to a higher one.

Testing stops at the first failing bit and reports that bit's index. A start pulse runs the test, and a done level reports the result. The RAM is assumed to be synchronous with one cycle of read latency.

Top module: `alias_line_tester`

## Requirements
- R1: After reset, `done`, `fail`, `fail_bit`, `ram_we` and `ram_addr` are all zero.
- R2: For bit k, the zero base uses target `1<<k` and alias `0`. The all-ones base uses target all-ones and alias all-ones with bit k cleared.
- R3: A `start` seen while idle launches bit 0, zero base, on the next cycle. Bits run in ascending order. Within a bit, the zero base runs before the all-ones base (when `DUAL_BASE` = 1).
- R4: Each step takes eight cycles on the RAM port, in this order:
  1. read target
  2. read alias
  3. write alias with 0
  4. write target with all-ones
  5. read target
  6. read alias
  7. write the saved alias value
  8. write the saved target value

  Read data is taken from `ram_rdata` one cycle after the read address.
- R5: A step fails when the target reads back other than all-ones or the alias reads back other than zero.
- R6: The run ends after the first failing step with `fail` = 1 and `fail_bit` = that step's bit index. A run with no failure covers every step and ends with `fail` = 0 and `fail_bit` = 0.
- R7: Saved values are written back in every step, including the failing one, so the RAM contents after a run equal those before it.
- R8: `done` rises in the cycle after the last restore write. It holds, with `fail` and `fail_bit` stable and `ram_we` low, until the next `start`; that `start` clears `done` and `fail`. While a run is in progress, `done` is 0.
- R9: `start` pulses during a run are ignored and leave the port sequence unchanged.
- R10: Two address lines shorted together, so that either reads as one when either is driven high, are reported at the lower of the two bits, through the all-ones base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch pulse, honoured only while idle |
| ram_addr | output | AW | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, valid one cycle after its address |
| done | output | 1 | Run finished; result valid |
| fail | output | 1 | An address line failed |
| fail_bit | output | $clog2(AW) | Index of the first failing address line |

## Verification
The bench injects four kinds of address-line fault into a behavioural RAM:
- a line stuck at zero in the middle of the address;
- a line stuck at one on bit 0;
- a line stuck at one on the most significant bit;
- a pair of bridged lines.

A design that skipped the all-ones base would let the bridge pass. A design that read one cycle too early would latch the previous location and report false failures. A design that skipped restoring in the failing step would leave the zeroed alias or all-ones target behind in the RAM.

A mid-run `start` pulse targets a controller that restarts while busy. The port sequence would then break from the expected cycle stream.

// File: rtl/alt_pkg.sv
package alt_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_T,
      ST_RD_A,
      ST_CLR_A,
      ST_SET_T,
      ST_CHK_T,
      ST_CHK_A,
      ST_RST_A,
      ST_RST_T
   } alt_state_e;
endpackage

// File: rtl/alt_addr_gen.sv
module alt_addr_gen #(
   parameter int AW        = 8,
   parameter int DUAL_BASE = 1,
   parameter int SW        = 4,
   parameter int BW        = 3
) (
   input  logic [SW-1:0] step,
   output logic [AW-1:0] tgt,
   output logic [AW-1:0] alias_addr,
   output logic [BW-1:0] bit_idx
);
   logic          base_ones;
   logic [AW-1:0] onehot;

   // parameter picks how a step index splits into bit and base
   if (DUAL_BASE != 0) begin : g_dual
      assign bit_idx   = step[SW-1:1];
      assign base_ones = step[0];
   end else begin : g_single
      assign bit_idx   = step;
      assign base_ones = 1'b0;
   end

   for (genvar i = 0; i < AW; i++) begin : g_mask
      assign onehot[i] = (bit_idx == BW'(i));
   end

   assign tgt        = base_ones ? {AW{1'b1}} : onehot;
   assign alias_addr = base_ones ? ~onehot    : {AW{1'b0}};
endmodule

// File: rtl/alt_verdict.sv
module alt_verdict
   import alt_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  alt_state_e    state,
   input  logic          clr,
   input  logic [DW-1:0] rdata,
   output logic [DW-1:0] save_t,
   output logic [DW-1:0] save_a,
   output logic          err
);
   logic bad_t;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         save_t <= '0;
         save_a <= '0;
         bad_t  <= 1'b0;
         err    <= 1'b0;
      end else begin
         if (clr) err <= 1'b0;
         unique case (state)
            ST_RD_A:  save_t <= rdata;  // target read issued one cycle earlier
            ST_CLR_A: save_a <= rdata;
            ST_CHK_A: bad_t  <= (rdata != {DW{1'b1}});
            ST_RST_A: if (bad_t || rdata != {DW{1'b0}}) err <= 1'b1;
            default: ;
         endcase
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);  // R6
endmodule

// File: rtl/alt_ctrl.sv
module alt_ctrl
   import alt_pkg::*;
#(
   parameter int AW        = 8,
   parameter int DUAL_BASE = 1,
   parameter int SW        = 4,
   parameter int BW        = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          err,
   input  logic [BW-1:0] cur_bit,
   output alt_state_e    state,
   output logic [SW-1:0] step,
   output logic          launch,
   output logic          done,
   output logic          fail,
   output logic [BW-1:0] fail_bit
);
   localparam int NSTEP = (DUAL_BASE != 0) ? 2 * AW : AW;
   localparam logic [SW-1:0] LAST = SW'(NSTEP - 1);

   assign launch = (state == ST_IDLE) && start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         step     <= '0;
         done     <= 1'b0;
         fail     <= 1'b0;
         fail_bit <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state    <= ST_RD_T;
               step     <= '0;
               done     <= 1'b0;
               fail     <= 1'b0;
               fail_bit <= '0;
            end
            ST_RD_T:  state <= ST_RD_A;
            ST_RD_A:  state <= ST_CLR_A;
            ST_CLR_A: state <= ST_SET_T;
            ST_SET_T: state <= ST_CHK_T;
            ST_CHK_T: state <= ST_CHK_A;
            ST_CHK_A: state <= ST_RST_A;
            ST_RST_A: state <= ST_RST_T;
            ST_RST_T: begin
               if (err || step == LAST) begin
                  state    <= ST_IDLE;
                  done     <= 1'b1;
                  fail     <= err;
                  fail_bit <= err ? cur_bit : '0;
               end else begin
                  state <= ST_RD_T;
                  step  <= step + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RST_T && !err && step != LAST)
      |=> (state == ST_RD_T && step == SW'($past(step) + 1'b1)));  // R3
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(fail) && $stable(fail_bit)));  // R8
endmodule

// File: rtl/alias_line_tester.sv
module alias_line_tester
   import alt_pkg::*;
#(
   parameter int AW        = 8,
   parameter int DW        = 8,
   parameter int DUAL_BASE = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   output logic [AW-1:0]         ram_addr,
   output logic                  ram_we,
   output logic [DW-1:0]         ram_wdata,
   input  logic [DW-1:0]         ram_rdata,
   output logic                  done,
   output logic                  fail,
   output logic [$clog2(AW)-1:0] fail_bit
);
   localparam int BW    = $clog2(AW);
   localparam int NSTEP = (DUAL_BASE != 0) ? 2 * AW : AW;
   localparam int SW    = $clog2(NSTEP);

   if (AW < 2) begin : g_chk_aw
      $error("alias_line_tester: AW must be at least 2");
   end
   if (DW < 1) begin : g_chk_dw
      $error("alias_line_tester: DW must be at least 1");
   end
   if (DUAL_BASE != 0 && DUAL_BASE != 1) begin : g_chk_db
      $error("alias_line_tester: DUAL_BASE must be 0 or 1");
   end

   alt_state_e    state;
   logic [SW-1:0] step;
   logic [AW-1:0] tgt, alias_addr;
   logic [BW-1:0] bit_idx;
   logic [DW-1:0] save_t, save_a;
   logic          err, launch;

   alt_addr_gen #(.AW(AW), .DUAL_BASE(DUAL_BASE), .SW(SW), .BW(BW)) u_gen (
      .step(step), .tgt(tgt), .alias_addr(alias_addr), .bit_idx(bit_idx));

   alt_ctrl #(.AW(AW), .DUAL_BASE(DUAL_BASE), .SW(SW), .BW(BW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .err(err), .cur_bit(bit_idx),
      .state(state), .step(step), .launch(launch),
      .done(done), .fail(fail), .fail_bit(fail_bit));

   alt_verdict #(.DW(DW)) u_verdict (
      .clk(clk), .rst_n(rst_n), .state(state), .clr(launch),
      .rdata(ram_rdata), .save_t(save_t), .save_a(save_a), .err(err));

   always_comb begin
      ram_addr  = '0;
      ram_we    = 1'b0;
      ram_wdata = '0;
      unique case (state)
         ST_RD_T, ST_CHK_T: ram_addr = tgt;
         ST_RD_A, ST_CHK_A: ram_addr = alias_addr;
         ST_CLR_A: begin ram_addr = alias_addr; ram_we = 1'b1; end
         ST_SET_T: begin ram_addr = tgt; ram_we = 1'b1; ram_wdata = {DW{1'b1}}; end
         ST_RST_A: begin ram_addr = alias_addr; ram_we = 1'b1; ram_wdata = save_a; end
         ST_RST_T: begin ram_addr = tgt; ram_we = 1'b1; ram_wdata = save_t; end
         default: ;
      endcase
   end

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ram_we);  // R8
   AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> done);  // R6
   AST_PASS_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail) |-> (fail_bit == '0));  // R6
   AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (ram_addr == tgt || ram_addr == alias_addr));  // R2
endmodule

// File: tb/sim_alias_line_tester.sv
module sim_alias_line_tester;
   localparam int AW   = 8;
   localparam int DW   = 8;
   localparam int BW   = $clog2(AW);
   localparam int NMEM = 1 << AW;
   localparam int AMSK = NMEM - 1;
   localparam int ONES = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] ram_addr;
   logic          ram_we;
   logic [DW-1:0] ram_wdata;
   logic [DW-1:0] ram_rdata = '0;
   logic          done, fail;
   logic [BW-1:0] fail_bit;

   int checks = 0, errors = 0, cyc = 0;
   int fk = 0, fb1 = 0, fb2 = 0;  // fault kind: 0 none, 1 stuck0, 2 stuck1, 3 bridge
   logic [DW-1:0] mem  [NMEM];
   logic [DW-1:0] snap [NMEM];
   logic [DW-1:0] mm   [NMEM];
   bit q_we[$];
   int q_ad[$];
   int q_wd[$];
   bit exp_fail;
   int exp_bit;

   always #10 clk = ~clk;

   alias_line_tester #(.AW(AW), .DW(DW), .DUAL_BASE(1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .done(done), .fail(fail), .fail_bit(fail_bit));

   function automatic int eff(input int a);
      int r = a;
      case (fk)
         1: r = a & ~(1 << fb1);
         2: r = a | (1 << fb1);
         3: if (((a >> fb1) & 1) != 0 || ((a >> fb2) & 1) != 0)
               r = a | (1 << fb1) | (1 << fb2);
         default: r = a;
      endcase
      return r & AMSK;
   endfunction

   // faulty synchronous RAM, one cycle read latency
   always @(posedge clk) begin
      if (ram_we) mem[eff(int'(ram_addr))] <= ram_wdata;
      ram_rdata <= mem[eff(int'(ram_addr))];
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL R8 watchdog: done=%0d expected 1", done);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic push(input bit we, input int ad, input int wd);
      q_we.push_back(we); q_ad.push_back(ad); q_wd.push_back(wd);
   endtask

   // reference: expected port stream and verdict from the requirements
   task automatic build();
      int t, a, st, sa, rt, ra;
      q_we.delete(); q_ad.delete(); q_wd.delete();
      exp_fail = 0; exp_bit = 0;
      for (int k = 0; k < AW; k++) begin
         for (int b = 0; b < 2; b++) begin
            t = b ? AMSK : (1 << k);               // R2
            a = b ? (AMSK & ~(1 << k)) : 0;
            st = mm[eff(t)]; sa = mm[eff(a)];
            mm[eff(a)] = '0;
            mm[eff(t)] = DW'(ONES);
            rt = mm[eff(t)]; ra = mm[eff(a)];
            mm[eff(a)] = DW'(sa);
            mm[eff(t)] = DW'(st);
            push(0, t, 0); push(0, a, 0); push(1, a, 0); push(1, t, ONES);   // R4
            push(0, t, 0); push(0, a, 0); push(1, a, sa); push(1, t, st);
            if (rt != ONES || ra != 0) begin  // R5
               exp_fail = 1; exp_bit = k;
               return;
            end
         end
      end
   endtask

   task automatic run_case(input string name, input int mid);
      bit bad;
      int n;
      for (int i = 0; i < NMEM; i++) begin snap[i] = mem[i]; mm[i] = mem[i]; end
      build();
      n = q_we.size();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int i = 0; i < n; i++) begin
         checks++;
         if (ram_we !== q_we[i] || int'(ram_addr) != q_ad[i] || done !== 1'b0 ||
             (q_we[i] && int'(ram_wdata) != q_wd[i])) begin
            errors++;
            $display("FAIL R3/R4 %s cycle %0d: we=%0d addr=%0h wd=%0h done=%0d expected we=%0d addr=%0h wd=%0h done=0",
                     name, i, ram_we, ram_addr, ram_wdata, done, q_we[i], q_ad[i], q_wd[i]);
         end
         start = (i == mid);  // R9 stray pulse mid-run
         @(negedge clk);
      end
      start = 1'b0;
      checks++;
      if (done !== 1'b1 || fail !== exp_fail || int'(fail_bit) != exp_bit) begin
         errors++;
         $display("FAIL R6 %s: done=%0d fail=%0d bit=%0d expected done=1 fail=%0d bit=%0d",
                  name, done, fail, fail_bit, exp_fail, exp_bit);
      end
      bad = 0;
      for (int i = 0; i < NMEM; i++) if (mem[i] !== snap[i]) bad = 1;
      checks++;
      if (bad) begin
         errors++;
         $display("FAIL R7 %s: memory changed=1 expected 0", name);
      end
      repeat (3) @(negedge clk);
      checks++;
      if (done !== 1'b1 || fail !== exp_fail || int'(fail_bit) != exp_bit || ram_we !== 1'b0) begin
         errors++;
         $display("FAIL R8 %s hold: done=%0d fail=%0d bit=%0d we=%0d expected 1 %0d %0d 0",
                  name, done, fail, fail_bit, ram_we, exp_fail, exp_bit);
      end
   endtask

   task automatic expect_result(input string tag, input bit ef, input int eb);
      checks++;
      if (exp_fail !== ef || exp_bit != eb || fail !== ef || int'(fail_bit) != eb) begin
         errors++;
         $display("FAIL %s: fail=%0d bit=%0d expected fail=%0d bit=%0d",
                  tag, fail, fail_bit, ef, eb);
      end
   endtask

   initial begin
      for (int i = 0; i < NMEM; i++) mem[i] = DW'($urandom);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;  // R1 reset state
      if (done !== 0 || fail !== 0 || fail_bit !== 0 || ram_we !== 0 || ram_addr !== 0) begin
         errors++;
         $display("FAIL R1: done=%0d fail=%0d bit=%0d we=%0d addr=%0h expected all 0",
                  done, fail, fail_bit, ram_we, ram_addr);
      end

      fk = 0; run_case("clean", -1);
      expect_result("R6 clean pass", 0, 0);

      fk = 0; run_case("clean_midstart", 20);
      expect_result("R9 start ignored", 0, 0);

      fk = 1; fb1 = 3; run_case("stuck0_b3", -1);
      expect_result("R5 stuck0 bit3", 1, 3);

      fk = 2; fb1 = 0; run_case("stuck1_b0", -1);
      expect_result("R5 stuck1 bit0", 1, 0);

      fk = 2; fb1 = AW - 1; run_case("stuck1_msb", -1);
      expect_result("R5 stuck1 msb", 1, AW - 1);

      fk = 3; fb1 = 2; fb2 = 5; run_case("bridge_2_5", -1);
      expect_result("R10 bridge", 1, 2);

      fk = 0; run_case("recover", -1);
      expect_result("R8 restart clears fail", 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule